// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

This block reads a 4x4 grid of push keys that has no filtering of its own. It drives the four row lines and reads the four column lines. The column lines are held high by pull-ups, so a closed key pulls its column to 0 only while its row is driven low. When no key is being handled, all rows are driven low, so any closed key shows up as a 0 on some column.

When a column goes low, the scanner takes a snapshot of the column pattern. One debounce interval later it samples the columns again. The press is accepted only when the two samples are equal. The scanner then drives one row low at a time to find the key. It reports a 4-bit key code together with a strobe that is high for one cycle. After that it waits until the keys are let go. A release is accepted only when all columns read 1 in two samples taken one debounce interval apart. Only then does the scanner look for a new press.

The clock rate and the debounce time in milliseconds are parameters. The nominal debounce time is 150 ms.

Top module: `keypad_scanner`

## Requirements
- R1: During reset and in the first cycle after it, `row_o` is 4'b0000, `key_valid_o` is 0 and `key_id_o` is 0.
- R2: While waiting for a press, and while waiting for a release, all four rows are driven low (`row_o` = 4'b0000).
- R3: A press is accepted only when the synchronised column pattern matches the snapshot taken DEB cycles earlier, where DEB = (CLK_HZ/1000)*DEBOUNCE_MS. A key that is held for less than DEB cycles produces no report.
- R4: To identify the key, the scanner drives exactly one row low at a time. Row 0 is driven first, then rows 1, 2 and 3 in that order, and the other rows are held high (row r active gives `row_o` = ~(1<<r)). Each row is held for SETTLE_CYCLES cycles before the columns are read.
- R5: The key code is row*4 + column. The first row in scan order that shows a low column wins, and within that row the lowest-numbered low column wins.
- R6: `key_valid_o` is high for exactly one cycle per accepted press. `key_id_o` changes only together with that strobe and holds its value between strobes.
- R7: After a report, no further report is made until all columns read 1 in two samples taken DEB cycles apart. A release that lasts less than DEB cycles, followed by pressing again, produces no new report.
- R8: If the identifying scan finds no low column in any row, for example because the key was let go during the scan, the scanner returns to waiting for a press without reporting. A later press is then reported normally.
- R9: Column inputs pass through a two-flop synchroniser. A report never comes sooner than DEB cycles after the press reaches `col_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_i | input | 4 | Column lines (pulled high; 0 = closed key on a low row) |
| row_o | output | 4 | Row drive (0 = row selected) |
| key_id_o | output | 4 | Code of the last accepted key, row*4+column |
| key_valid_o | output | 1 | One-cycle strobe marking a new key code |

## Verification
A key closed at `col_i` takes two cycles to pass the synchroniser. One more cycle is spent taking the snapshot, then DEB cycles pass before the confirming sample. The row walk then takes at most 4*SETTLE_CYCLES cycles, and the strobe register adds one more cycle. The bench therefore splits each press into two windows: the first DEB cycles, in which no strobe may appear, and a following window of 4*SETTLE_CYCLES+16 cycles, in which exactly one strobe must appear with the expected code. During that second window the bench also records the order of the row patterns the scanner drives. The bench checks the silence after a report, after a short release, after a press shorter than the debounce interval, and after a press that ends during the row walk. Each of these windows spans several debounce intervals, which is longer than any path through the scanner. All outputs are sampled on the falling edge.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int unsigned KP_ROWS  = 4;
    localparam int unsigned KP_COLS  = 4;
    localparam int unsigned KP_ROW_W = $clog2(KP_ROWS);
    localparam int unsigned KP_COL_W = $clog2(KP_COLS);
    localparam int unsigned KP_ID_W  = KP_ROW_W + KP_COL_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESS_WAIT,
        ST_SCAN,
        ST_HOLD,
        ST_REL_WAIT
    } kp_state_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, meta_d, stab_q, stab_d;

        always_comb begin
            meta_d = d_i[b];
            stab_d = meta_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
        end

        assign q_o[b] = stab_q;
    end
endmodule

// File: rtl/kp_timer.sv
module kp_timer #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/kp_col_find.sv
module kp_col_find #(
    parameter int unsigned COLS = 4,
    localparam int unsigned IW  = $clog2(COLS)
) (
    input  logic [COLS-1:0] cols_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!cols_i[c]) begin
                found_o = 1'b1;
                idx_o   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kp_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned DEBOUNCE_MS   = 150,
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   col_i,
    output logic [3:0]   row_o,
    output logic [3:0]   key_id_o,
    output logic         key_valid_o
);
    localparam int unsigned DEB_CYCLES = (CLK_HZ / 1000) * DEBOUNCE_MS;
    localparam int unsigned SW         = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        kp_state_e             state;
        logic [KP_ROW_W-1:0]   row;
        logic [KP_COLS-1:0]    snap;
        logic [SW-1:0]         settle;
        logic                  valid;
        logic [KP_ID_W-1:0]    id;
    } scan_t;

    scan_t               r_q, r_d;
    logic [KP_COLS-1:0]  col_s;
    logic                tmr_start;
    logic                tmr_expired;
    logic                hit;
    logic [KP_COL_W-1:0] hit_col;

    kp_sync #(.WIDTH(KP_COLS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (col_i),
        .q_o   (col_s)
    );

    kp_timer #(.CYCLES(DEB_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start),
        .expired_o (tmr_expired)
    );

    kp_col_find #(.COLS(KP_COLS)) u_find (
        .cols_i  (col_s),
        .found_o (hit),
        .idx_o   (hit_col)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        tmr_start = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.settle = '0;
                if (col_s != '1) begin
                    r_d.snap  = col_s;
                    tmr_start = 1'b1;
                    r_d.state = ST_PRESS_WAIT;
                end
            end
            ST_PRESS_WAIT: begin
                if (tmr_expired) begin
                    if (col_s == r_q.snap) begin
                        r_d.state  = ST_SCAN;
                        r_d.row    = '0;
                        r_d.settle = '0;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_SCAN: begin
                if (r_q.settle == SW'(SETTLE_CYCLES - 1)) begin
                    r_d.settle = '0;
                    if (hit) begin
                        r_d.valid = 1'b1;
                        r_d.id    = {r_q.row, hit_col};
                        r_d.state = ST_HOLD;
                    end else if (r_q.row == KP_ROW_W'(KP_ROWS - 1)) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.row = r_q.row + 1'b1;
                    end
                end else begin
                    r_d.settle = r_q.settle + 1'b1;
                end
            end
            ST_HOLD: begin
                if (col_s == '1) begin
                    tmr_start = 1'b1;
                    r_d.state = ST_REL_WAIT;
                end
            end
            ST_REL_WAIT: begin
                if (tmr_expired) begin
                    r_d.state = (col_s == '1) ? ST_IDLE : ST_HOLD;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.row    <= '0;
            r_q.snap   <= '1;
            r_q.settle <= '0;
            r_q.valid  <= 1'b0;
            r_q.id     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        row_o = '0;
        if (r_q.state == ST_SCAN) begin
            row_o = ~(KP_ROWS'(1) << r_q.row);
        end
    end

    assign key_id_o    = r_q.id;
    assign key_valid_o = r_q.valid;
endmodule

// File: rtl/kp_scan_checks.sv
module kp_scan_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] row_o,
    input logic [3:0] key_id_o,
    input logic       key_valid_o
);
    // R2 / R4: rows are either all low or exactly one low
    a_r4_row_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (row_o == 4'b0000) || ($countones(~row_o) == 1));

    // R6: strobe lasts one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    // R6: code changes only with the strobe
    a_r6_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid_o |-> $stable(key_id_o));

    // R5: reported row equals the row driven low in the cycle before
    a_r5_row_of_id: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> ((~$past(row_o)) == (4'b0001 << key_id_o[3:2])));

    // R2 / R7: once reported, all rows go low while waiting for release
    a_r7_rows_low_after_report: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> (row_o == 4'b0000));
endmodule

bind keypad_scanner kp_scan_checks u_scan_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_o       (row_o),
    .key_id_o    (key_id_o),
    .key_valid_o (key_valid_o)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
    localparam int unsigned CLK_HZ = 2000;
    localparam int unsigned DEB_MS = 10;
    localparam int unsigned SETTLE = 4;
    localparam int unsigned DEB    = (CLK_HZ / 1000) * DEB_MS;
    localparam int unsigned WIN    = 4 * SETTLE + 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_i;
    logic [3:0] row_o;
    logic [3:0] key_id_o;
    logic       key_valid_o;
    logic [15:0] pressed = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses;
    logic [3:0] last_id;
    int rows_seen;
    logic rows_ok;

    always #10 clk = ~clk;

    keypad_scanner #(
        .CLK_HZ(CLK_HZ), .DEBOUNCE_MS(DEB_MS), .SETTLE_CYCLES(SETTLE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .col_i(col_i), .row_o(row_o),
        .key_id_o(key_id_o), .key_valid_o(key_valid_o)
    );

    // key matrix model with pull-ups
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_i[c] = 1'b1;
            for (int r = 0; r < 4; r++) begin
                if (pressed[r*4+c] && !row_o[r]) col_i[c] = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // observe n cycles at negedge: count strobes, record row walk order
    task automatic observe(input int n);
        logic [3:0] prev;
        pulses = 0;
        rows_seen = 0;
        rows_ok = 1'b1;
        prev = row_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (key_valid_o) begin
                pulses++;
                last_id = key_id_o;
            end
            if (row_o != prev && row_o != 4'b0000) begin
                if (row_o != ~(4'b0001 << rows_seen)) rows_ok = 1'b0;
                rows_seen++;
            end
            prev = row_o;
        end
    endtask

    task automatic release_all();
        pressed = '0;
        observe(3 * DEB + 10);
        check(pulses == 0, "R7", pulses, 0);
        check(row_o == 4'b0000, "R2", row_o, 0);
    endtask

    task automatic press_expect(input logic [15:0] keys, input int exp_id, input int exp_row);
        @(negedge clk);
        pressed = keys;
        observe(DEB);
        check(pulses == 0, "R9", pulses, 0);
        observe(WIN);
        check(pulses == 1, "R6", pulses, 1);
        check(last_id == 4'(exp_id), "R5", last_id, exp_id);
        check(rows_ok && rows_seen == exp_row + 1, "R4", rows_seen, exp_row + 1);
        observe(3 * DEB);
        check(pulses == 0, "R7", pulses, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(row_o == 4'b0000, "R1", row_o, 0);
        check(key_valid_o == 1'b0, "R1", key_valid_o, 0);
        check(key_id_o == 4'd0, "R1", key_id_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(row_o == 4'b0000 && !key_valid_o && key_id_o == 0, "R1", row_o, 0);
        observe(2 * DEB);
        check(pulses == 0, "R2", pulses, 0);

        // every key individually: R4, R5
        for (int k = 0; k < 16; k++) begin
            press_expect(16'(1) << k, k, k / 4);
            release_all();
        end

        // R5 priority: rows 1 and 3 -> row 1 wins
        press_expect(16'(1 << 6) | 16'(1 << 13), 6, 1);
        release_all();
        // R5 priority: same row, columns 1 and 3 -> column 1 wins
        press_expect(16'(1 << 9) | 16'(1 << 11), 9, 2);
        release_all();

        // R3: press shorter than debounce interval
        @(negedge clk);
        pressed = 16'(1 << 7);
        observe(DEB / 2);
        pressed = '0;
        observe(2 * DEB + WIN);
        check(pulses == 0, "R3", pulses, 0);

        // R7: short release then re-press does not re-report
        press_expect(16'(1 << 5), 5, 1);
        pressed = '0;
        observe(DEB / 2);
        pressed = 16'(1 << 5);
        observe(4 * DEB);
        check(pulses == 0, "R7", pulses, 0);
        release_all();

        // R8: released during the row walk (row 3 key)
        @(negedge clk);
        pressed = 16'(1 << 14);
        observe(DEB + 4);
        pressed = '0;
        observe(2 * DEB + WIN);
        check(pulses == 0, "R8", pulses, 0);
        check(row_o == 4'b0000, "R8", row_o, 0);
        press_expect(16'(1 << 2), 2, 0);
        release_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule